// File: doc/BRIEF.md
# CEC Frame Transmitter

This block sends one frame on the single-wire consumer-electronics control bus. The line is open-drain, so the block only ever pulls it low through `driveLow` and reads the resolved level back on `lineIn`. Software loads up to sixteen bytes as packed 32-bit words and sets a length code. It then raises `startTx`. The block first waits for the line to be free. It then sends a start bit followed by the bytes. Each byte is sent as eight data bits, most significant first, then an end-of-message bit and an acknowledge slot.

The acknowledge slot is sampled in every byte. When a follower fails to acknowledge, the block repeats the whole frame once. If the second try is also refused, it reports failure. The result is shown by `txGood` and by a sticky interrupt that stays set until it is acknowledged. A soft reset aborts the frame at any point.

All timing counts tick periods. One tick lasts `TICK_CYCLES` clocks, and 50 µs of bus time is one tick at the default values.

Top module: `cec_tx`

## Requirements
- R1: After the idle check, the start bit pulls the line low for 74 ticks and lasts 90 ticks in total.
- R2: Each data bit lasts 48 ticks. It pulls the line low for 12 ticks for a 1 and for 30 ticks for a 0. Bits are sent most significant bit first.
- R3: Byte n is taken from `txData[8n+7:8n]`, so byte 0 is the header byte. Each 32-bit word holds four bytes, little-endian. `msgLenM1 + 1` bytes are sent. The end-of-message bit, sent right after the eight data bits, is 1 only on the last byte. The acknowledge slot is driven as a 1.
- R4: The line is sampled 21 ticks into each acknowledge slot, and a low level counts as an acknowledge. When every byte is acknowledged, `txGood` and `txIrq` both go to 1 in the clock after the final slot ends.
- R5: A missing acknowledge ends the attempt at the end of that slot. The block then makes exactly one new attempt, starting again with the idle check and the start bit. If the second attempt is also refused, it finishes with `txGood`=0 and `txIrq`=1.
- R6: During the eight data bits of the header byte, a 1 bit is checked at the sample point. If the line reads low there, arbitration is lost. The frame ends at once with `txGood`=0 and `txIrq`=1, and no retry is made.
- R7: `txIrq` stays at 1 until `irqAck` is pulsed. `txGood` is cleared when a new frame is accepted.
- R8: A frame is accepted only on a 0-to-1 change of `startTx` while the block is idle and not in soft reset. Keeping `startTx` high starts nothing new. A rising edge during a frame is ignored.
- R9: `txSoftReset` aborts any frame and releases the line in the next clock. It raises no interrupt, and it blocks start edges while it is held.
- R10: Before each attempt, the line must read high for 336 consecutive ticks (`IDLE_T`). A low level restarts this count.
- R11: Out of reset, the line is released and `txGood` and `txIrq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txData | input | 32*WORDS | Packed message bytes; must be held for the whole frame |
| msgLenM1 | input | LEN_W | Byte count minus one |
| startTx | input | 1 | Starts a frame on its rising edge |
| txSoftReset | input | 1 | Aborts any frame and holds the transmitter idle |
| irqAck | input | 1 | Clears the interrupt |
| lineIn | input | 1 | Resolved level of the bus line |
| driveLow | output | 1 | 1 pulls the line low |
| txGood | output | 1 | Last frame was fully acknowledged |
| txIrq | output | 1 | Sticky frame-completion interrupt |

## Verification
The bench builds the expected line waveform of every attempt tick by tick, including the retry. It also plays a follower that pulls the line in the acknowledge slots. Several corner cases are targeted:

- A refusal on a middle byte that then succeeds on the retry. A design that retried from the refused byte, or retried twice, would drift from the expected waveform.
- A header 1 bit overridden by another initiator. A design that retried after the loss would keep driving the line.
- A sixteen-byte frame. A wrong word or lane index would flip data bits.
- A `startTx` held high or toggled in mid-frame. A level-triggered start would resend the frame.
- A soft reset in mid-frame with a start edge inside it. A design that ignored the reset would keep pulling the line low or would raise a spurious interrupt.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_START,
    ST_BIT
  } txState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic idleClr;
    logic idleInc;
    logic phaseClr;
    logic frameClr;
    logic bitAdv;
    logic driveStart;
    logic driveBit;
  } dpCtl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic tick;
    logic idleDone;
    logic startEnd;
    logic bitEnd;
    logic atSample;
    logic bitVal;
    logic ackSlot;
    logic lastByte;
    logic headerData;
  } dpStat_t;

endpackage

// File: rtl/cec_tx_datapath.sv
module cec_tx_datapath
  import cec_tx_pkg::*;
#(
  parameter int WORDS          = 4,
  parameter int LEN_W          = 4,
  parameter int TICK_CYCLES    = 2500,
  parameter int START_LOW_T    = 74,
  parameter int START_PERIOD_T = 90,
  parameter int BIT_PERIOD_T   = 48,
  parameter int ONE_LOW_T      = 12,
  parameter int ZERO_LOW_T     = 30,
  parameter int SAMPLE_T       = 21,
  parameter int IDLE_T         = 336
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [32*WORDS-1:0]  txData,
  input  logic [LEN_W-1:0]     msgLenM1,
  input  dpCtl_t               ctl,
  output dpStat_t              st,
  output logic                 driveLow
);

  localparam int PH_MAX = (START_PERIOD_T > BIT_PERIOD_T) ? START_PERIOD_T : BIT_PERIOD_T;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int ID_W   = $clog2(IDLE_T + 1);
  localparam int PS_W   = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

  logic             tick;
  logic [PH_W-1:0]  phase;
  logic [ID_W-1:0]  idleCnt;
  logic [3:0]       bitIdx;
  logic [LEN_W-1:0] byteIdx;
  logic [7:0]       curByte;
  logic             bitVal;
  logic             isLast;

  // tick prescaler
  generate
    if (TICK_CYCLES == 1) begin : gFastTick
      assign tick = 1'b1;
    end else begin : gDivTick
      logic [PS_W-1:0] preCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) preCnt <= '0;
        else if (preCnt == PS_W'(TICK_CYCLES - 1)) preCnt <= '0;
        else preCnt <= preCnt + PS_W'(1);
      end
      assign tick = (preCnt == PS_W'(TICK_CYCLES - 1));
    end
  endgenerate

  // shared phase counter for start bit and data bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else if (ctl.phaseClr) phase <= '0;
    else if (tick && phase != PH_W'(PH_MAX)) phase <= phase + PH_W'(1);
  end

  // free-line counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idleCnt <= '0;
    else if (ctl.idleClr) idleCnt <= '0;
    else if (ctl.idleInc) idleCnt <= idleCnt + ID_W'(1);
  end

  // bit and byte position within the frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx  <= '0;
      byteIdx <= '0;
    end else if (ctl.frameClr) begin
      bitIdx  <= '0;
      byteIdx <= '0;
    end else if (ctl.bitAdv) begin
      if (bitIdx == 4'd9) begin
        bitIdx  <= '0;
        byteIdx <= byteIdx + LEN_W'(1);
      end else begin
        bitIdx <= bitIdx + 4'd1;
      end
    end
  end

  assign curByte = txData[{byteIdx, 3'b000} +: 8];
  assign isLast  = (byteIdx == msgLenM1);

  always_comb begin
    if (bitIdx < 4'd8)       bitVal = curByte[~bitIdx[2:0]];
    else if (bitIdx == 4'd8) bitVal = isLast;
    else                     bitVal = 1'b1;
  end

  assign driveLow = (ctl.driveStart && phase < PH_W'(START_LOW_T)) ||
                    (ctl.driveBit && phase < (bitVal ? PH_W'(ONE_LOW_T) : PH_W'(ZERO_LOW_T)));

  assign st.tick       = tick;
  assign st.idleDone   = (idleCnt == ID_W'(IDLE_T - 1));
  assign st.startEnd   = tick && phase == PH_W'(START_PERIOD_T - 1);
  assign st.bitEnd     = tick && phase == PH_W'(BIT_PERIOD_T - 1);
  assign st.atSample   = tick && phase == PH_W'(SAMPLE_T);
  assign st.bitVal     = bitVal;
  assign st.ackSlot    = (bitIdx == 4'd9);
  assign st.lastByte   = isLast;
  assign st.headerData = (byteIdx == '0) && (bitIdx < 4'd8);

  // a bit never outruns its period
  assert_phase_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.driveBit |-> phase < PH_W'(BIT_PERIOD_T));

  // no byte past the programmed length is sent
  assert_byte_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.driveBit |-> byteIdx <= msgLenM1);

endmodule

// File: rtl/cec_tx_ctrl.sv
module cec_tx_ctrl
  import cec_tx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startTx,
  input  logic    txSoftReset,
  input  logic    irqAck,
  input  logic    lineIn,
  input  dpStat_t st,
  output dpCtl_t  ctl,
  output logic    txGood,
  output logic    txIrq
);

  txState_e state, nextState;
  logic startQ, attempt, ackSeen;
  logic accept, finish, finOk, retry;

  always_comb begin
    ctl       = '0;
    nextState = state;
    accept    = 1'b0;
    finish    = 1'b0;
    finOk     = 1'b0;
    retry     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startTx && !startQ && !txSoftReset) begin
          accept      = 1'b1;
          ctl.idleClr = 1'b1;
          nextState   = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (st.tick) begin
          if (!lineIn) ctl.idleClr = 1'b1;
          else if (st.idleDone) begin
            ctl.phaseClr = 1'b1;
            ctl.frameClr = 1'b1;
            nextState    = ST_START;
          end else ctl.idleInc = 1'b1;
        end
      end
      ST_START: begin
        ctl.driveStart = 1'b1;
        if (st.startEnd) begin
          ctl.phaseClr = 1'b1;
          nextState    = ST_BIT;
        end
      end
      ST_BIT: begin
        ctl.driveBit = 1'b1;
        if (st.atSample && st.headerData && st.bitVal && !lineIn) begin
          finish    = 1'b1;
          nextState = ST_IDLE;
        end else if (st.bitEnd) begin
          ctl.phaseClr = 1'b1;
          if (st.ackSlot && !ackSeen) begin
            if (!attempt) begin
              retry       = 1'b1;
              ctl.idleClr = 1'b1;
              nextState   = ST_WAIT;
            end else begin
              finish    = 1'b1;
              nextState = ST_IDLE;
            end
          end else if (st.ackSlot && st.lastByte) begin
            finish    = 1'b1;
            finOk     = 1'b1;
            nextState = ST_IDLE;
          end else begin
            ctl.bitAdv = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      startQ  <= 1'b0;
      attempt <= 1'b0;
      ackSeen <= 1'b0;
      txGood  <= 1'b0;
      txIrq   <= 1'b0;
    end else begin
      startQ <= startTx;
      if (txSoftReset) begin
        state   <= ST_IDLE;
        attempt <= 1'b0;
        if (irqAck) txIrq <= 1'b0;
      end else begin
        state <= nextState;
        if (accept) begin
          attempt <= 1'b0;
          txGood  <= 1'b0;
        end
        if (retry) attempt <= 1'b1;
        if (state == ST_BIT && st.atSample && st.ackSlot) ackSeen <= !lineIn;
        if (finish) txGood <= finOk;
        if (finish) txIrq <= 1'b1;
        else if (irqAck) txIrq <= 1'b0;
      end
    end
  end

  // success is never shown without the completion interrupt
  assert_good_with_irq_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txGood) |-> txIrq);

  // a retry always restarts from the free-line wait
  assert_retry_waits_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(attempt) |-> state == ST_WAIT);

  // interrupt is sticky until acknowledged
  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (txIrq && !irqAck) |=> txIrq);

endmodule

// File: rtl/cec_tx.sv
module cec_tx
  import cec_tx_pkg::*;
#(
  parameter int WORDS          = 4,
  parameter int TICK_CYCLES    = 2500,
  parameter int START_LOW_T    = 74,
  parameter int START_PERIOD_T = 90,
  parameter int BIT_PERIOD_T   = 48,
  parameter int ONE_LOW_T      = 12,
  parameter int ZERO_LOW_T     = 30,
  parameter int SAMPLE_T       = 21,
  parameter int IDLE_T         = 336,
  localparam int LEN_W         = $clog2(WORDS * 4)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [32*WORDS-1:0] txData,
  input  logic [LEN_W-1:0]    msgLenM1,
  input  logic                startTx,
  input  logic                txSoftReset,
  input  logic                irqAck,
  input  logic                lineIn,
  output logic                driveLow,
  output logic                txGood,
  output logic                txIrq
);

  dpCtl_t  ctl;
  dpStat_t st;

  cec_tx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startTx(startTx), .txSoftReset(txSoftReset),
    .irqAck(irqAck), .lineIn(lineIn), .st(st), .ctl(ctl),
    .txGood(txGood), .txIrq(txIrq)
  );

  cec_tx_datapath #(
    .WORDS(WORDS), .LEN_W(LEN_W), .TICK_CYCLES(TICK_CYCLES),
    .START_LOW_T(START_LOW_T), .START_PERIOD_T(START_PERIOD_T),
    .BIT_PERIOD_T(BIT_PERIOD_T), .ONE_LOW_T(ONE_LOW_T),
    .ZERO_LOW_T(ZERO_LOW_T), .SAMPLE_T(SAMPLE_T), .IDLE_T(IDLE_T)
  ) u_dp (
    .clk(clk), .rstN(rstN), .txData(txData), .msgLenM1(msgLenM1),
    .ctl(ctl), .st(st), .driveLow(driveLow)
  );

  // soft reset frees the line one clock later
  assert_soft_reset_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    txSoftReset |=> !driveLow);

endmodule

// File: tb/cec_tx_tb.sv
module cec_tx_tb;

  localparam int START_LOW = 74, START_PER = 90, BIT_PER = 48;
  localparam int ONE_LOW = 12, ZERO_LOW = 30, SAMPLE = 21, IDLE = 20;

  logic clk = 0, rstN = 0;
  logic [127:0] txData = '0;
  logic [3:0] msgLenM1 = '0;
  logic startTx = 0, txSoftReset = 0, irqAck = 0;
  logic follow = 0;
  logic lineIn, driveLow, txGood, txIrq;

  int checks = 0, errors = 0;
  string curReq = "R11";
  logic [7:0] msg [16];
  // entry: [0] drive, [1] follower pull, [2] done, [3] good, [4] clear good
  bit [4:0] expQ [$];
  logic expIrq = 0, expGood = 0;

  always #5 clk = ~clk;
  assign lineIn = ~(driveLow | follow);

  cec_tx #(.WORDS(4), .TICK_CYCLES(1), .IDLE_T(IDLE)) u_dut (
    .clk(clk), .rstN(rstN), .txData(txData), .msgLenM1(msgLenM1),
    .startTx(startTx), .txSoftReset(txSoftReset), .irqAck(irqAck),
    .lineIn(lineIn), .driveLow(driveLow), .txGood(txGood), .txIrq(txIrq)
  );

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, compared every clock
  always @(negedge clk) begin
    bit [4:0] e;
    e = '0;
    if (expQ.size() > 0) e = expQ.pop_front();
    if (e[4]) expGood = 0;
    if (e[2]) begin expIrq = 1; expGood = e[3]; end
    follow = e[1];
    check({curReq, " line"}, driveLow, e[0]);
    check({curReq, " irq"}, txIrq, expIrq);
    check({curReq, " good"}, txGood, expGood);
  end

  task automatic pushRun(bit d, bit f, int n);
    repeat (n) expQ.push_back({3'b000, f, d});
  endtask

  // result: 0 acked, 1 refused, 2 arbitration lost
  task automatic buildAttempt(int nBytes, int busy, int nackByte, int arbBit, output int res);
    pushRun(0, 1, busy);
    pushRun(0, 0, IDLE);
    pushRun(1, 0, START_LOW);
    pushRun(0, 0, START_PER - START_LOW);
    for (int b = 0; b < nBytes; b++) begin
      for (int i = 0; i < 10; i++) begin
        bit v;
        int lowLen, pullLen;
        v = (i < 8) ? msg[b][7-i] : (i == 8) ? (b == nBytes - 1) : 1'b1;
        lowLen = v ? ONE_LOW : ZERO_LOW;
        pullLen = (i == 9 && b != nackByte) ? ZERO_LOW : 0;
        if (b == 0 && i == arbBit) begin
          for (int p = 0; p <= SAMPLE; p++) expQ.push_back({3'b000, p < ZERO_LOW, p < ONE_LOW});
          res = 2;
          return;
        end
        for (int p = 0; p < BIT_PER; p++) expQ.push_back({3'b000, p < pullLen, p < lowLen});
        if (i == 9 && b == nackByte) begin res = 1; return; end
      end
    end
    res = 0;
  endtask

  task automatic launch(string tag, int nBytes, int busy, int nack0, int nack1, int arbBit,
                        output bit ok);
    int res;
    @(negedge clk); #1;
    curReq = tag;
    for (int i = 0; i < 16; i++) txData[8*i +: 8] = msg[i];
    msgLenM1 = 4'(nBytes - 1);
    startTx = 1;
    buildAttempt(nBytes, busy, nack0, arbBit, res);
    expQ[0][4] = 1;
    if (res == 1) buildAttempt(nBytes, 0, nack1, -1, res);
    ok = (res == 0);
    expQ.push_back({1'b0, ok, 3'b100});
  endtask

  task automatic sendFrame(string tag, int nBytes, int busy, int nack0, int nack1, int arbBit,
                           bit keepStart);
    bit ok;
    launch(tag, nBytes, busy, nack0, nack1, arbBit, ok);
    while (expQ.size() > 0) @(negedge clk);
    #1;
    check({tag, " final good"}, txGood, ok);
    check({tag, " final irq"}, txIrq, 1'b1);
    if (!keepStart) startTx = 0;
  endtask

  task automatic ackIrq();
    @(negedge clk); #1;
    irqAck = 1; expIrq = 0;
    @(negedge clk); #1;
    irqAck = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 line", driveLow, 1'b0);
    check("R11 good", txGood, 1'b0);
    check("R11 irq", txIrq, 1'b0);
    @(negedge clk); #1 rstN = 1;

    // single byte, start kept high afterwards
    msg[0] = 8'hA5;
    sendFrame("R1 R2 R4", 1, 0, -1, -1, -1, 1);
    curReq = "R8 held";
    repeat (200) @(negedge clk);
    #1 startTx = 0;
    curReq = "R7";
    repeat (30) @(negedge clk);
    check("R7 irq still set", txIrq, 1'b1);
    ackIrq();

    // three bytes, mixed bit values
    msg[0] = 8'h40; msg[1] = 8'h04; msg[2] = 8'h8F;
    sendFrame("R3 short", 3, 0, -1, -1, -1, 0);
    ackIrq();

    // full length frame
    for (int i = 0; i < 16; i++) msg[i] = 8'(i * 17 + 3);
    sendFrame("R3 full", 16, 0, -1, -1, -1, 0);
    ackIrq();

    // refusal on byte 1, success on retry
    msg[0] = 8'h10; msg[1] = 8'h36; msg[2] = 8'hC3;
    sendFrame("R5 retry ok", 3, 0, 1, -1, -1, 0);
    ackIrq();

    // refused twice
    sendFrame("R5 fail", 2, 0, 0, 0, -1, 0);
    ackIrq();

    // arbitration lost on header bit 1
    msg[0] = 8'h4F;
    sendFrame("R6", 2, 0, -1, -1, 1, 0);
    ackIrq();

    // busy line before start
    msg[0] = 8'h3C;
    sendFrame("R10", 1, 37, -1, -1, -1, 0);
    ackIrq();

    // start edge during a frame is ignored
    msg[0] = 8'h21; msg[1] = 8'h9A;
    fork
      sendFrame("R8 midframe", 2, 0, -1, -1, -1, 0);
      begin
        repeat (300) @(negedge clk);
        #2 startTx = 0;
        @(negedge clk); #2 startTx = 1;
      end
    join
    ackIrq();

    // soft reset mid-frame
    begin
      bit ok;
      msg[0] = 8'h55; msg[1] = 8'hAA;
      launch("R9", 2, 0, -1, -1, -1, ok);
      repeat (250) @(negedge clk);
      #1 txSoftReset = 1;
      expQ.delete();
      curReq = "R9 abort";
      repeat (2) @(negedge clk);
      #1 startTx = 0;
      repeat (2) @(negedge clk);
      #1 startTx = 1;
      repeat (2) @(negedge clk);
      #1 txSoftReset = 0;
      repeat (150) @(negedge clk);
      check("R9 no irq", txIrq, 1'b0);
      check("R9 line free", driveLow, 1'b0);
      #1 startTx = 0;
    end
    sendFrame("R9 recover", 2, 0, -1, -1, -1, 0);
    ackIrq();

    repeat (10) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(150000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule